// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This block is a synchronous controller for the dual-rail power switching on a motherboard. Two active-high sleep-control inputs, one for suspend-to-RAM (`slp_s3`) and one for soft-off (`slp_s5`), are filtered and decoded into three system states: active, suspend and soft-off. From the state it drives three digital enables. The first releases the pull-down on the main-rail pass gates. The second turns on the standby P-channel switch that feeds standby 5 V into the dual 5 V rail. The third enables the auxiliary standby regulator.

Decoding is stateful. The code with only `slp_s3` high is illegal and leaves the state as it is. Soft-off can never step straight to suspend. Leaving the active state for suspend is delayed by a programmable time, while leaving it for soft-off takes effect at once. Entry into the active state needs the 12 V good flag. It is deferred until that flag and the active code have been present together for three soft-start periods, and all three enables then change in one cycle.

Loss of the standby-supply good flag resets the block asynchronously. While the flag is low, all three enables are held at their safe levels. After the flag returns, the block waits one soft-start period before it decodes the inputs. All delays are parameters counted in clock cycles.

Top module: `sleep_rail_seq`

## Requirements
- R1: While `stby_ok` is low, all three enables are 0, and this takes effect immediately without waiting for a clock. After `stby_ok` rises, all three stay 0 for SOFTSTART_CYC clock edges.
- R2: Each control input passes through its own filter. A new level is accepted only after it has differed from the accepted level for DEGLITCH_CYC consecutive clock edges. A pulse shorter than that has no effect on the outputs.
- R3: The suspend code is `slp_s5`=1 with `slp_s3`=0. In the suspend state the enables are `aux_ldo_en`=1, `stby_sw_en`=1 and `gate_release`=0.
- R4: The soft-off code is both inputs at 0. In the soft-off state only `aux_ldo_en` is 1. From any state after start-up, soft-off is entered on the edge after the filtered code changes (DEGLITCH_CYC+1 edges after the raw change).
- R5: The illegal code (`slp_s5`=0, `slp_s3`=1) leaves the state and the outputs unchanged.
- R6: The suspend code has no effect in soft-off. The block stays in soft-off until the active code appears.
- R7: The active code is both inputs at 1. The active state (`gate_release`=1, `stby_sw_en`=0, `aux_ldo_en`=0, all switching in the same cycle) is entered only after `rail12_ok` and the active code have been present together for 3*SOFTSTART_CYC consecutive clock edges.
- R8: While waiting to wake, the outputs keep the values of the sleep state that was left: `stby_sw_en` stays 1 when waking from suspend and 0 when waking from soft-off. Any cycle with `rail12_ok` low restarts the 3*SOFTSTART_CYC count.
- R9: In the active state, the suspend code starts a hold of SUSP_DELAY_CYC edges. During the hold the outputs keep their active values. The active code during the hold cancels it.
- R10: At the end of the start-up wait, the filtered code chooses the first state. The suspend code gives suspend. The active code starts the wake wait as if waking from soft-off. Any other code gives soft-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| stby_ok | input | 1 | Standby-supply good flag; low is an asynchronous reset |
| rail12_ok | input | 1 | 12 V rail good flag |
| slp_s3 | input | 1 | Suspend-to-RAM sleep control, active high |
| slp_s5 | input | 1 | Soft-off sleep control, active high |
| gate_release | output | 1 | 1 releases the pass-gate pull-down so the main rails connect |
| stby_sw_en | output | 1 | 1 turns on the standby switch that feeds standby 5 V to the dual rail |
| aux_ldo_en | output | 1 | 1 enables the auxiliary standby regulator; 0 puts it in standby |

## Verification
The hardest case to reach from the ports is a wake count that restarts part-way through. The bench lets `rail12_ok` pulse low inside the three-period window. It then checks that the enables are still in their sleep values at a time when an unrestarted count would already have released the gates. A second hard case is the suspend hold that is cancelled by the active code before it expires. The bench reaches it by changing the code again inside the hold window. The behavioural model runs on every edge and compares against the design, so an exact one-edge timing of the immediate soft-off entry is also checked.

// File: rtl/slpseq_pkg.sv
package slpseq_pkg;

   // Filtered control code: bit 1 = slp_s5, bit 0 = slp_s3
   localparam logic [1:0] CODE_OFF  = 2'b00;
   localparam logic [1:0] CODE_BAD  = 2'b01;
   localparam logic [1:0] CODE_SUSP = 2'b10;
   localparam logic [1:0] CODE_RUN  = 2'b11;

   typedef enum logic [2:0] {
      PH_BOOT,
      PH_OFF,
      PH_SUSP,
      PH_WAKE,
      PH_RUN,
      PH_DOZE
   } phase_t;

   typedef struct packed {
      logic gate_rel;
      logic sw_en;
      logic ldo_en;
   } rail_ctl_t;

endpackage

// File: rtl/lvl_filter.sv
module lvl_filter #(
   parameter int STABLE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;

   generate
      if (STABLE_CYC == 1) begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clean <= 1'b0;
            else        clean <= raw;
         end
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clean <= 1'b0;
               cnt   <= '0;
            end else if (raw == clean) begin
               cnt <= '0;
            end else if (cnt == LAST) begin
               clean <= raw;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
   import slpseq_pkg::*;
#(
   parameter int SS_CYC   = 16,
   parameter int DOZE_CYC = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] code,
   input  logic       rail12_ok,
   output phase_t     phase,
   output logic       from_susp
);
   localparam int WAKE_CYC = 3 * SS_CYC;
   localparam int MAXC     = (WAKE_CYC > DOZE_CYC) ? WAKE_CYC : DOZE_CYC;
   localparam int TW       = $clog2(MAXC);
   localparam logic [TW-1:0] SS_LAST   = TW'(SS_CYC - 1);
   localparam logic [TW-1:0] WAKE_LAST = TW'(WAKE_CYC - 1);
   localparam logic [TW-1:0] DOZE_LAST = TW'(DOZE_CYC - 1);

   phase_t        ph_n;
   logic [TW-1:0] tmr, tmr_n;
   logic          fs_n;

   always_comb begin
      ph_n  = phase;
      tmr_n = tmr;
      fs_n  = from_susp;
      case (phase)
         PH_BOOT: begin
            if (tmr == SS_LAST) begin
               tmr_n = '0;
               if (code == CODE_SUSP)     ph_n = PH_SUSP;
               else if (code == CODE_RUN) begin ph_n = PH_WAKE; fs_n = 1'b0; end
               else                       ph_n = PH_OFF;
            end else begin
               tmr_n = tmr + 1'b1;
            end
         end
         PH_OFF: begin
            if (code == CODE_RUN) begin ph_n = PH_WAKE; tmr_n = '0; fs_n = 1'b0; end
         end
         PH_SUSP: begin
            if (code == CODE_RUN)      begin ph_n = PH_WAKE; tmr_n = '0; fs_n = 1'b1; end
            else if (code == CODE_OFF) ph_n = PH_OFF;
         end
         PH_WAKE: begin
            if (code == CODE_OFF)       ph_n = PH_OFF;
            else if (code == CODE_SUSP) ph_n = from_susp ? PH_SUSP : PH_OFF;
            else if (code == CODE_RUN) begin
               if (!rail12_ok)             tmr_n = '0;
               else if (tmr == WAKE_LAST) begin ph_n = PH_RUN; tmr_n = '0; end
               else                        tmr_n = tmr + 1'b1;
            end
         end
         PH_RUN: begin
            if (code == CODE_SUSP)     begin ph_n = PH_DOZE; tmr_n = '0; end
            else if (code == CODE_OFF) ph_n = PH_OFF;
         end
         PH_DOZE: begin
            if (code == CODE_RUN)      ph_n = PH_RUN;
            else if (code == CODE_OFF) ph_n = PH_OFF;
            else if (code == CODE_SUSP) begin
               if (tmr == DOZE_LAST) begin ph_n = PH_SUSP; tmr_n = '0; end
               else                  tmr_n = tmr + 1'b1;
            end
         end
         default: ph_n = PH_BOOT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_BOOT;
         tmr       <= '0;
         from_susp <= 1'b0;
      end else begin
         phase     <= ph_n;
         tmr       <= tmr_n;
         from_susp <= fs_n;
      end
   end

endmodule

// File: rtl/rail_decode.sv
module rail_decode
   import slpseq_pkg::*;
(
   input  phase_t    phase,
   input  logic      from_susp,
   output rail_ctl_t ctl
);
   always_comb begin
      ctl = '{gate_rel: 1'b0, sw_en: 1'b0, ldo_en: 1'b0};
      case (phase)
         PH_OFF:  ctl.ldo_en = 1'b1;
         PH_SUSP: begin ctl.ldo_en = 1'b1; ctl.sw_en = 1'b1; end
         PH_WAKE: begin ctl.ldo_en = 1'b1; ctl.sw_en = from_susp; end
         PH_RUN, PH_DOZE: ctl.gate_rel = 1'b1;
         default: ctl = '{gate_rel: 1'b0, sw_en: 1'b0, ldo_en: 1'b0};
      endcase
   end
endmodule

// File: rtl/sleep_rail_seq.sv
module sleep_rail_seq
   import slpseq_pkg::*;
#(
   parameter int DEGLITCH_CYC   = 250,
   parameter int SOFTSTART_CYC  = 2050000,
   parameter int SUSP_DELAY_CYC = 15000
) (
   input  logic clk,
   input  logic stby_ok,
   input  logic rail12_ok,
   input  logic slp_s3,
   input  logic slp_s5,
   output logic gate_release,
   output logic stby_sw_en,
   output logic aux_ldo_en
);
   localparam int NCTL = 2;

   generate
      if (DEGLITCH_CYC < 1) begin : g_bad_dg
         $error("DEGLITCH_CYC must be at least 1");
      end
      if (SOFTSTART_CYC < 2) begin : g_bad_ss
         $error("SOFTSTART_CYC must be at least 2");
      end
      if (SUSP_DELAY_CYC < 2) begin : g_bad_sd
         $error("SUSP_DELAY_CYC must be at least 2");
      end
   endgenerate

   logic [NCTL-1:0] raw_code;
   logic [NCTL-1:0] code;
   phase_t          phase;
   logic            from_susp;
   rail_ctl_t       ctl;

   assign raw_code = {slp_s5, slp_s3};

   generate
      for (genvar i = 0; i < NCTL; i++) begin : g_flt
         lvl_filter #(.STABLE_CYC(DEGLITCH_CYC)) flt_i (
            .clk   (clk),
            .rst_n (stby_ok),
            .raw   (raw_code[i]),
            .clean (code[i])
         );
      end
   endgenerate

   sleep_fsm #(.SS_CYC(SOFTSTART_CYC), .DOZE_CYC(SUSP_DELAY_CYC)) fsm_i (
      .clk       (clk),
      .rst_n     (stby_ok),
      .code      (code),
      .rail12_ok (rail12_ok),
      .phase     (phase),
      .from_susp (from_susp)
   );

   rail_decode dec_i (
      .phase     (phase),
      .from_susp (from_susp),
      .ctl       (ctl)
   );

   assign gate_release = ctl.gate_rel;
   assign stby_sw_en   = ctl.sw_en;
   assign aux_ldo_en   = ctl.ldo_en;

endmodule

// File: rtl/sleep_rail_seq_chk.sv
module sleep_rail_seq_chk (
   input logic clk,
   input logic stby_ok,
   input logic rail12_ok,
   input logic gate_release,
   input logic stby_sw_en,
   input logic aux_ldo_en
);
   AST_SAFE_IN_RESET: assert property (@(posedge clk)
      !stby_ok |-> (!gate_release && !stby_sw_en && !aux_ldo_en)); // R1

   AST_SWITCH_WITH_LDO: assert property (@(posedge clk) disable iff (!stby_ok)
      stby_sw_en |-> aux_ldo_en); // R3

   AST_NO_OFF_TO_SUSP: assert property (@(posedge clk) disable iff (!stby_ok)
      $rose(stby_sw_en) |-> !$past(aux_ldo_en)); // R6

   AST_RELEASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!stby_ok)
      gate_release |-> (!stby_sw_en && !aux_ldo_en)); // R7

   AST_RELEASE_NEEDS_12V: assert property (@(posedge clk) disable iff (!stby_ok)
      $rose(gate_release) |-> $past(rail12_ok)); // R7

   AST_RELEASE_FROM_WAKE: assert property (@(posedge clk) disable iff (!stby_ok)
      $rose(gate_release) |-> $past(aux_ldo_en)); // R8
endmodule

bind sleep_rail_seq sleep_rail_seq_chk chk_i (
   .clk          (clk),
   .stby_ok      (stby_ok),
   .rail12_ok    (rail12_ok),
   .gate_release (gate_release),
   .stby_sw_en   (stby_sw_en),
   .aux_ldo_en   (aux_ldo_en)
);

// File: tb/sleep_rail_seq_tb_top.sv
`timescale 1ns/100ps
module sleep_rail_seq_tb_top;
   localparam int DG = 3;
   localparam int SS = 8;
   localparam int SD = 20;
   localparam int W  = 3 * SS;

   logic clk = 1'b0;
   logic stby_ok = 1'b0;
   logic rail12_ok = 1'b0;
   logic slp_s3 = 1'b0;
   logic slp_s5 = 1'b0;
   logic gate_release, stby_sw_en, aux_ldo_en;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sleep_rail_seq #(.DEGLITCH_CYC(DG), .SOFTSTART_CYC(SS), .SUSP_DELAY_CYC(SD)) dut_i (
      .clk(clk), .stby_ok(stby_ok), .rail12_ok(rail12_ok),
      .slp_s3(slp_s3), .slp_s5(slp_s5),
      .gate_release(gate_release), .stby_sw_en(stby_sw_en), .aux_ldo_en(aux_ldo_en)
   );

   // Behavioural reference: mode 0 boot, 1 off, 2 suspend, 3 wake, 4 run, 5 doze
   int m_mode = 0;
   int m_rem = SS;
   bit m_fs = 1'b0;
   bit f5 = 1'b0, f3 = 1'b0;
   int c5 = 0, c3 = 0;
   bit is_run, is_sus, is_off;

   always @(posedge clk or negedge stby_ok) begin
      if (!stby_ok) begin
         m_mode = 0; m_rem = SS; m_fs = 1'b0;
         f5 = 1'b0; f3 = 1'b0; c5 = 0; c3 = 0;
      end else begin
         is_run = f5 && f3;
         is_sus = f5 && !f3;
         is_off = !f5 && !f3;
         case (m_mode)
            0: if (m_rem == 1) begin
                  if (is_sus) m_mode = 2;
                  else if (is_run) begin m_mode = 3; m_rem = W; m_fs = 1'b0; end
                  else m_mode = 1;
               end else m_rem--;
            1: if (is_run) begin m_mode = 3; m_rem = W; m_fs = 1'b0; end
            2: if (is_run) begin m_mode = 3; m_rem = W; m_fs = 1'b1; end
               else if (is_off) m_mode = 1;
            3: if (is_off) m_mode = 1;
               else if (is_sus) m_mode = m_fs ? 2 : 1;
               else if (is_run) begin
                  if (!rail12_ok) m_rem = W;
                  else if (m_rem == 1) m_mode = 4;
                  else m_rem--;
               end
            4: if (is_sus) begin m_mode = 5; m_rem = SD; end
               else if (is_off) m_mode = 1;
            5: if (is_run) m_mode = 4;
               else if (is_off) m_mode = 1;
               else if (is_sus) begin
                  if (m_rem == 1) m_mode = 2; else m_rem--;
               end
            default: m_mode = 0;
         endcase
         if (slp_s5 != f5) begin c5++; if (c5 == DG) begin f5 = slp_s5; c5 = 0; end end
         else c5 = 0;
         if (slp_s3 != f3) begin c3++; if (c3 == DG) begin f3 = slp_s3; c3 = 0; end end
         else c3 = 0;
      end
   end

   function automatic logic [2:0] model_out(int mode, bit fs);
      case (mode)
         1: return 3'b001;
         2: return 3'b011;
         3: return {1'b0, fs, 1'b1};
         4, 5: return 3'b100;
         default: return 3'b000;
      endcase
   endfunction

   function automatic string mode_req(int mode);
      case (mode)
         0: return "R1";
         1: return "R4";
         2: return "R3";
         3: return "R8";
         4: return "R7";
         default: return "R9";
      endcase
   endfunction

   always @(negedge clk) begin
      if (!done) begin
         compared++;
         if ({gate_release, stby_sw_en, aux_ldo_en} !== model_out(m_mode, m_fs)) begin
            mismatched++;
            $display("FAIL %s model compare at %0t: actual %b expected %b",
                     mode_req(m_mode), $time, {gate_release, stby_sw_en, aux_ldo_en},
                     model_out(m_mode, m_fs));
         end
      end
   end

   // outputs order: {gate_release, stby_sw_en, aux_ldo_en}
   task automatic expect_out(string tag, logic [2:0] exp);
      compared++;
      if ({gate_release, stby_sw_en, aux_ldo_en} !== exp) begin
         mismatched++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time,
                  {gate_release, stby_sw_en, aux_ldo_en}, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drive(bit s5, bit s3);
      slp_s5 = s5;
      slp_s3 = s3;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      mismatched++;
      $display("FAIL watchdog expired: actual hung expected finished");
      finish_run();
   end

   initial begin
      step(3);
      expect_out("R1 held in reset", 3'b000);
      stby_ok = 1'b1;
      step(SS - 2);
      expect_out("R1 start-up wait", 3'b000);
      step(4);
      expect_out("R10 boot into soft-off", 3'b001);

      drive(1, 1); step(DG - 1); drive(0, 0); step(10);
      expect_out("R2 short pulse ignored", 3'b001);

      drive(1, 0); step(30);
      expect_out("R6 soft-off to suspend blocked", 3'b001);

      drive(1, 1); step(50);
      expect_out("R7 no wake without 12V", 3'b001);
      rail12_ok = 1'b1; step(10);
      rail12_ok = 1'b0; step(2);
      rail12_ok = 1'b1; step(W - 5);
      expect_out("R8 12V drop restarts wake count", 3'b001);
      step(10);
      expect_out("R7 active after wake count", 3'b100);

      drive(0, 1); step(20);
      expect_out("R5 illegal code holds active", 3'b100);

      drive(1, 0); step(DG + SD - 6);
      expect_out("R9 suspend entry delayed", 3'b100);
      drive(1, 1); step(10);
      expect_out("R9 active code cancels hold", 3'b100);
      drive(1, 0); step(40);
      expect_out("R3 suspend outputs", 3'b011);

      drive(0, 1); step(20);
      expect_out("R5 illegal code holds suspend", 3'b011);

      drive(1, 1); step(DG + 3);
      expect_out("R8 wake from suspend keeps switch", 3'b011);
      step(40);
      expect_out("R7 active after suspend wake", 3'b100);

      drive(0, 0); step(DG);
      expect_out("R4 not yet off before filter+1", 3'b100);
      step(1);
      expect_out("R4 immediate soft-off", 3'b001);

      stby_ok = 1'b0; step(2);
      expect_out("R1 reset from soft-off", 3'b000);
      drive(1, 0); step(1);
      stby_ok = 1'b1; step(SS + 3);
      expect_out("R10 boot into suspend", 3'b011);

      drive(1, 1); step(60);
      expect_out("R7 active from suspend", 3'b100);
      stby_ok = 1'b0; #0.5;
      expect_out("R1 asynchronous reset", 3'b000);
      step(2);
      stby_ok = 1'b1; step(SS + 4);
      expect_out("R10 boot with active code waits", 3'b001);
      step(W + 2);
      expect_out("R10 boot then active", 3'b100);

      step(3);
      finish_run();
   end

endmodule